// File: doc/BRIEF.md
# Transaction response validator

This block checks a stream of response transaction headers against the requests issued earlier. Each request header is pushed into an in-order queue as it is sent. Responses arrive one 32-bit word at a time. The first word of every transaction is its header, and any body words follow it. Each response header is matched against the oldest queued request. The body words are counted against the size the response header implies.

When a transaction closes, the block runs a fixed, ordered set of checks. It reports one pass/fail result and the code of the highest-priority failure. Failure classes stay sticky for the whole packet, one flag per class. At the end of a packet the block gives an overall verdict. Requests that never received a response count as a failure. The queue is then emptied for the next packet.

Top module: `txn_rsp_checker`

## Requirements
- R1: Header layout, used for both requests and responses: transaction ID in bits [11:0], type in bits [15:12], word count in bits [23:16], direction in bit 24 (1 = response), result code in bits [31:28]. The first response word after reset or after a closing word is a header. A word with `rsp_eot_i` or `rsp_pkt_end_i` high closes the transaction. Each response header takes the oldest queued request.
- R2: A response whose type differs from its request's type gives code 2.
- R3: A response whose 12-bit transaction ID differs from its request's ID gives code 3. IDs are compared only for equality, so the sequence 4095 then 0 is legal.
- R4: A response header with direction bit 24 at 0 (marked as a request) gives code 4.
- R5: The body word count must match the size the response header implies, or the result is code 5. That size is the word count for types 0 and 2, zero for types 1 and 3, and one for types 4 and 5. Any other type always fails with code 5.
- R6: A non-zero result field gives code 6.
- R7: Only one code is reported per transaction, chosen by priority 1 > 2 > 3 > 4 > 5 > 6. `txn_done_o` pulses one cycle after the closing word, carrying `txn_code_o`. `txn_pass_o` is 1 exactly when the code is 0.
- R8: A response header that arrives with the queue empty gives code 1 and removes nothing from the queue.
- R9: Requests still queued when the packet ends set flag bit 0 and fail the packet. The queue is emptied at that word.
- R10: `err_flags_o` bit (code−1) is set for every failing transaction code. The flags stay set through the packet and are cleared by the first word of the next packet.
- R11: `pkt_done_o` pulses one cycle after the `rsp_pkt_end_i` word. `pkt_pass_o` is 1 exactly when no flag is set for that packet.
- R12: The queue holds QDEPTH (80) requests. A push while the queue is full is dropped and sets `q_ovf_o`, which stays set until reset.
- R13: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Push a request header |
| req_hdr_i | input | 32 | Request header |
| rsp_valid_i | input | 1 | Response word valid |
| rsp_word_i | input | 32 | Response word (header or body) |
| rsp_eot_i | input | 1 | Last word of the transaction |
| rsp_pkt_end_i | input | 1 | Last word of the packet (also closes the transaction) |
| txn_done_o | output | 1 | Transaction result pulse |
| txn_pass_o | output | 1 | Transaction passed |
| txn_code_o | output | 3 | Latched failure code (0 = pass) |
| err_flags_o | output | 6 | Sticky per-class flags for the current packet |
| pkt_done_o | output | 1 | Packet verdict pulse |
| pkt_pass_o | output | 1 | Packet passed |
| q_ovf_o | output | 1 | Sticky request queue overflow |

## Verification
Most faults in the queue pointers or the head entry show up quickly. They appear at the next response header as a type or ID mismatch code, reported one cycle after that transaction closes. A stale body counter or stored expected size shows as a wrong code 5 on the first multi-word transaction. A flag register that is not cleared between packets only shows later. It appears as a failed `pkt_pass_o` or as nonzero `err_flags_o` during the next packet. A queue that is not emptied at packet end pairs the next packet's first response with an old request, which fails immediately.

// File: rtl/rv_pkg.sv
package rv_pkg;
  localparam int HDR_W   = 32;
  localparam int ID_W    = 12;
  localparam int TYPE_W  = 4;
  localparam int WORDS_W = 8;
  localparam int RES_W   = 4;
  localparam int BODY_W  = WORDS_W + 1;
  localparam int NCLASS  = 6;

  typedef enum logic [2:0] {
    CHK_OK    = 3'd0,
    CHK_NOREQ = 3'd1,
    CHK_TYPE  = 3'd2,
    CHK_ID    = 3'd3,
    CHK_DIR   = 3'd4,
    CHK_SIZE  = 3'd5,
    CHK_RES   = 3'd6
  } chk_code_e;

  typedef struct packed {
    logic [RES_W-1:0]   res;
    logic [2:0]         rsv;
    logic               dir;
    logic [WORDS_W-1:0] words;
    logic [TYPE_W-1:0]  ttype;
    logic [ID_W-1:0]    id;
  } hdr_t;

  // only the fields a response is matched against are queued
  typedef struct packed {
    logic [TYPE_W-1:0] ttype;
    logic [ID_W-1:0]   id;
  } req_t;
endpackage

// File: rtl/rv_req_fifo.sv
module rv_req_fifo #(
  parameter int DEPTH = 80,
  parameter int W     = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [W-1:0]                 data_i,
  input  logic                         pop_i,
  input  logic                         flush_i,
  output logic [W-1:0]                 head_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic                         drop_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push_i && (!full_o || flush_i);
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign drop_o  = push_i && !push_ok;
  assign head_o  = mem[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= wr_q;
      wr_q  <= push_ok ? inc(wr_q) : wr_q;
      cnt_q <= push_ok ? CNT_W'(1) : '0;
    end else begin
      if (push_ok) wr_q <= inc(wr_q);
      if (pop_ok)  rd_q <= inc(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_pop_nonempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_full_drop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (count_o == $past(count_o)));
  p_pop_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !flush_i) |=> (count_o == $past(count_o) - 1'b1));
endmodule

// File: rtl/rv_hdr_cmp.sv
module rv_hdr_cmp
  import rv_pkg::*;
(
  input  req_t              req_i,
  input  logic [HDR_W-1:0]  rsp_i,
  input  logic              avail_i,
  output chk_code_e         code_o,
  output logic              res_bad_o,
  output logic              unk_o,
  output logic [BODY_W-1:0] exp_o
);
  hdr_t rsp;
  logic unused_rsv;

  assign rsp        = hdr_t'(rsp_i);
  assign unused_rsv = ^rsp.rsv;

  // priority among header-only checks; size and result resolve at close
  always_comb begin
    if (!avail_i)                    code_o = CHK_NOREQ;
    else if (rsp.ttype != req_i.ttype) code_o = CHK_TYPE;
    else if (rsp.id != req_i.id)     code_o = CHK_ID;
    else if (!rsp.dir)               code_o = CHK_DIR;
    else                             code_o = CHK_OK;
  end

  assign res_bad_o = (rsp.res != '0);

  always_comb begin
    unk_o = 1'b0;
    exp_o = '0;
    case (rsp.ttype)
      4'd0, 4'd2: exp_o = {1'b0, rsp.words};
      4'd1, 4'd3: exp_o = '0;
      4'd4, 4'd5: exp_o = BODY_W'(1);
      default:    unk_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/rv_txn_eval.sv
module rv_txn_eval
  import rv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [HDR_W-1:0] word_i,
  input  logic             eot_i,
  input  logic             pkt_end_i,
  input  req_t             head_i,
  input  logic             avail_i,
  output logic             pop_o,
  output logic             close_o,
  output chk_code_e        code_o
);
  logic              open_q, res_q, unk_q;
  chk_code_e         hcode_q;
  logic [BODY_W-1:0] exp_q, cnt_q;

  chk_code_e         hcode_c, hcode;
  logic              res_c, unk_c, res, unk, is_hdr, size_bad;
  logic [BODY_W-1:0] exp_c, exp_v, cnt_nxt;

  rv_hdr_cmp u_cmp (
    .req_i    (head_i),
    .rsp_i    (word_i),
    .avail_i  (avail_i),
    .code_o   (hcode_c),
    .res_bad_o(res_c),
    .unk_o    (unk_c),
    .exp_o    (exp_c)
  );

  assign is_hdr  = !open_q;
  assign cnt_nxt = is_hdr ? '0 : ((cnt_q == '1) ? cnt_q : cnt_q + 1'b1);
  assign hcode   = is_hdr ? hcode_c : hcode_q;
  assign res     = is_hdr ? res_c : res_q;
  assign unk     = is_hdr ? unk_c : unk_q;
  assign exp_v   = is_hdr ? exp_c : exp_q;

  assign close_o  = valid_i && (eot_i || pkt_end_i);
  assign pop_o    = valid_i && is_hdr && avail_i;
  assign size_bad = unk || (cnt_nxt != exp_v);

  always_comb begin
    if (hcode != CHK_OK) code_o = hcode;
    else if (size_bad)   code_o = CHK_SIZE;
    else if (res)        code_o = CHK_RES;
    else                 code_o = CHK_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      hcode_q <= CHK_OK;
      res_q   <= 1'b0;
      unk_q   <= 1'b0;
      exp_q   <= '0;
      cnt_q   <= '0;
    end else if (valid_i) begin
      open_q <= !close_o;
      cnt_q  <= cnt_nxt;
      if (is_hdr) begin
        hcode_q <= hcode_c;
        res_q   <= res_c;
        unk_q   <= unk_c;
        exp_q   <= exp_c;
      end
    end
  end

  p_noreq_no_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !avail_i) |-> !pop_o);
endmodule

// File: rtl/txn_rsp_checker.sv
module txn_rsp_checker
  import rv_pkg::*;
#(
  parameter int QDEPTH = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [31:0]       req_hdr_i,
  input  logic              rsp_valid_i,
  input  logic [31:0]       rsp_word_i,
  input  logic              rsp_eot_i,
  input  logic              rsp_pkt_end_i,
  output logic              txn_done_o,
  output logic              txn_pass_o,
  output logic [2:0]        txn_code_o,
  output logic [NCLASS-1:0] err_flags_o,
  output logic              pkt_done_o,
  output logic              pkt_pass_o,
  output logic              q_ovf_o
);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  req_t              req_ent, head;
  logic              empty, full, drop, pop, close, flush, leftover;
  logic [CNT_W-1:0]  qcnt;
  chk_code_e         fin;
  logic [NCLASS-1:0] flag_add, flags_nxt, flags_q;
  logic              in_pkt_q, unused_req, unused_full;

  assign req_ent.ttype = req_hdr_i[15:12];
  assign req_ent.id    = req_hdr_i[11:0];
  assign unused_req    = ^req_hdr_i[31:16];
  assign unused_full   = full;
  assign flush         = rsp_valid_i && rsp_pkt_end_i;

  rv_req_fifo #(.DEPTH(QDEPTH), .W($bits(req_t))) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (req_valid_i),
    .data_i (req_ent),
    .pop_i  (pop),
    .flush_i(flush),
    .head_o (head),
    .empty_o(empty),
    .full_o (full),
    .drop_o (drop),
    .count_o(qcnt)
  );

  rv_txn_eval u_eval (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (rsp_valid_i),
    .word_i   (rsp_word_i),
    .eot_i    (rsp_eot_i),
    .pkt_end_i(rsp_pkt_end_i),
    .head_i   (head),
    .avail_i  (!empty),
    .pop_o    (pop),
    .close_o  (close),
    .code_o   (fin)
  );

  // requests not consumed by this packet, counting a pop in this cycle
  assign leftover = (qcnt != '0) && !(pop && qcnt == CNT_W'(1));

  always_comb begin
    flag_add = '0;
    if (close && fin != CHK_OK) flag_add = NCLASS'(1) << (3'(fin) - 3'd1);
    if (flush && leftover)      flag_add[0] = 1'b1;
    flags_nxt = (in_pkt_q ? flags_q : '0) | flag_add;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q    <= '0;
      in_pkt_q   <= 1'b0;
      txn_done_o <= 1'b0;
      txn_pass_o <= 1'b0;
      txn_code_o <= '0;
      pkt_done_o <= 1'b0;
      pkt_pass_o <= 1'b0;
      q_ovf_o    <= 1'b0;
    end else begin
      txn_done_o <= close;
      pkt_done_o <= flush;
      q_ovf_o    <= q_ovf_o | drop;
      if (close) begin
        txn_code_o <= 3'(fin);
        txn_pass_o <= (fin == CHK_OK);
      end
      if (rsp_valid_i) begin
        flags_q  <= flags_nxt;
        in_pkt_q <= !rsp_pkt_end_i;
      end
      if (flush) pkt_pass_o <= (flags_nxt == '0);
    end
  end

  assign err_flags_o = flags_q;

  p_txn_after_close_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_done_o |-> $past(rsp_valid_i && (rsp_eot_i || rsp_pkt_end_i)));
  p_fail_flagged_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_done_o && !txn_pass_o) |-> |(err_flags_o & (NCLASS'(1) << (txn_code_o - 3'd1))));
  p_pkt_after_end_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> $past(rsp_valid_i && rsp_pkt_end_i));
  p_pkt_pass_clean_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_o && pkt_pass_o) |-> (err_flags_o == '0));
  p_ovf_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_ovf_o |=> q_ovf_o);
endmodule

// File: tb/tb_txn_rsp_checker.sv
`timescale 1ns/1ps
module tb_txn_rsp_checker;
  logic        clk_i = 0, rst_ni = 0;
  logic        req_valid_i = 0, rsp_valid_i = 0, rsp_eot_i = 0, rsp_pkt_end_i = 0;
  logic [31:0] req_hdr_i = 0, rsp_word_i = 0;
  logic        txn_done_o, txn_pass_o, pkt_done_o, pkt_pass_o, q_ovf_o;
  logic [2:0]  txn_code_o;
  logic [5:0]  err_flags_o;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] mq[$];
  logic [5:0]  mflags = 0;
  bit          new_pkt = 1;
  bit          movf = 0;

  always #4 clk_i = ~clk_i;

  txn_rsp_checker dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int id, input int ty, input int wd, input int dir, input int res);
    return {4'(res), 3'b0, 1'(dir), 8'(wd), 4'(ty), 12'(id)};
  endfunction

  function automatic int exp_body(input logic [31:0] h, output bit unk);
    unk = 0;
    if (h[15:12] == 0 || h[15:12] == 2) return int'(h[23:16]);
    if (h[15:12] == 1 || h[15:12] == 3) return 0;
    if (h[15:12] == 4 || h[15:12] == 5) return 1;
    unk = 1;
    return 0;
  endfunction

  function automatic int model_code(input bit avail, input logic [31:0] rq, input logic [31:0] rs, input int nbody);
    bit unk;
    int eb;
    eb = exp_body(rs, unk);
    if (!avail) return 1;
    if (rs[15:12] != rq[15:12]) return 2;
    if (rs[11:0] != rq[11:0]) return 3;
    if (!rs[24]) return 4;
    if (unk || nbody != eb) return 5;
    if (rs[31:28] != 0) return 6;
    return 0;
  endfunction

  task automatic push(input logic [31:0] h);
    req_valid_i = 1; req_hdr_i = h;
    @(negedge clk_i);
    req_valid_i = 0;
    if (mq.size() < 80) mq.push_back(h); else movf = 1;
  endtask

  task automatic word(input logic [31:0] w, input bit eot, input bit pe);
    rsp_valid_i = 1; rsp_word_i = w; rsp_eot_i = eot; rsp_pkt_end_i = pe;
    @(negedge clk_i);
    rsp_valid_i = 0; rsp_eot_i = 0; rsp_pkt_end_i = 0;
  endtask

  // sends one response transaction and checks its verdict
  task automatic rsp(input logic [31:0] h, input int nbody, input bit last, input string tag);
    bit avail;
    logic [31:0] rq;
    int code;
    avail = mq.size() > 0;
    rq = avail ? mq[0] : 32'h0;
    code = model_code(avail, rq, h, nbody);
    if (avail) void'(mq.pop_front());
    if (new_pkt) begin mflags = 0; new_pkt = 0; end
    if (code != 0) mflags[code-1] = 1'b1;
    word(h, nbody == 0, last && nbody == 0);
    for (int i = 0; i < nbody; i++)
      word(32'(i * 7 + 3), i == nbody - 1, last && i == nbody - 1);
    chk(txn_done_o == 1, {tag, " R7 done"}, txn_done_o, 1);
    chk(txn_code_o == 3'(code), {tag, " R7 code"}, txn_code_o, code);
    chk(txn_pass_o == (code == 0), {tag, " R7 pass"}, txn_pass_o, code == 0);
    if (last) begin
      if (mq.size() > 0) mflags[0] = 1'b1;
      mq.delete();
      new_pkt = 1;
      chk(pkt_done_o == 1, {tag, " R11 pkt_done"}, pkt_done_o, 1);
      chk(pkt_pass_o == (mflags == 0), {tag, " R11 pkt_pass"}, pkt_pass_o, mflags == 0);
    end
    chk(err_flags_o == mflags, {tag, " R10 flags"}, err_flags_o, mflags);
  endtask

  task automatic rsp_for(input logic [31:0] rq, input bit last, input string tag);
    bit unk;
    logic [31:0] h;
    h = rq | 32'h0100_0000;
    rsp(h, exp_body(h, unk), last, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R7 act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n, nr, idb, c, nb;
    bit unk;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk({txn_done_o, txn_pass_o, txn_code_o, err_flags_o, pkt_done_o, pkt_pass_o, q_ovf_o} == 0,
        "R13 reset", {txn_done_o, txn_pass_o, txn_code_o, err_flags_o, pkt_done_o, pkt_pass_o, q_ovf_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 R3: matching read plus ID wrap 4095 -> 0, packet passes (R11)
    push(mk(4095, 0, 3, 0, 0)); push(mk(0, 1, 2, 0, 0)); push(mk(1, 4, 0, 0, 0));
    rsp_for(mk(4095, 0, 3, 0, 0), 0, "R1 read");
    rsp_for(mk(0, 1, 2, 0, 0), 0, "R3 wrap");
    rsp_for(mk(1, 4, 0, 0, 0), 1, "R1 rmw last");

    // R2 type+id wrong -> 2 (priority R7); R3 id; R4 dir with bad result -> 4; R6
    push(mk(5, 0, 1, 0, 0)); push(mk(6, 1, 0, 0, 0)); push(mk(7, 3, 0, 0, 0)); push(mk(8, 5, 0, 0, 0));
    rsp(mk(9, 1, 0, 1, 0), 0, 0, "R2 type");
    rsp(mk(16, 1, 0, 1, 0), 0, 0, "R3 id");
    rsp(mk(7, 3, 0, 0, 5), 0, 0, "R4 dir");
    rsp(mk(8, 5, 0, 1, 2), 1, 1, "R6 result");

    // R5: short body, long body, unknown type
    push(mk(10, 0, 2, 0, 0)); push(mk(11, 1, 0, 0, 0)); push(mk(12, 9, 0, 0, 0));
    rsp(mk(10, 0, 2, 1, 0), 1, 0, "R5 short");
    rsp(mk(11, 1, 0, 1, 3), 1, 0, "R5 long over result");
    rsp(mk(12, 9, 0, 1, 0), 0, 1, "R5 unknown");

    // R8: response with empty queue, then R10: flags cleared by a passing next packet
    rsp(mk(20, 0, 0, 1, 0), 0, 0, "R8 noreq");
    push(mk(21, 1, 0, 0, 0));
    rsp_for(mk(21, 1, 0, 0, 0), 1, "R8 after noreq");
    push(mk(22, 0, 1, 0, 0)); push(mk(23, 0, 0, 0, 0));
    rsp_for(mk(22, 0, 1, 0, 0), 0, "R10 cleared");

    // R9: leftover request fails packet; next packet proves the flush
    rsp(mk(99, 0, 0, 1, 0), 0, 0, "R9 extra");
    rsp(mk(99, 0, 0, 1, 0), 0, 1, "R9 end");
    push(mk(30, 1, 0, 0, 0)); push(mk(31, 1, 0, 0, 0));
    rsp_for(mk(30, 1, 0, 0, 0), 1, "R9 leftover");
    push(mk(40, 2, 2, 0, 0));
    rsp_for(mk(40, 2, 2, 0, 0), 1, "R9 flushed");

    // random packets
    idb = 4090;
    for (int p = 0; p < 60; p++) begin
      n = 1 + $urandom_range(0, 5);
      for (int k = 0; k < n; k++) begin
        push(mk((idb + k) % 4096, $urandom_range(0, 5), $urandom_range(0, 4), 0, 0));
      end
      c = $urandom_range(0, 9);
      nr = (c == 0) ? n - 1 : (c == 1) ? n + 1 : n;
      for (int k = 0; k < nr; k++) begin
        r = (k < n) ? mk((idb + k) % 4096, 0, 0, 0, 0) : mk(7, 0, 0, 1, 0);
        r = (k < mq.size()) ? mq[0] | 32'h0100_0000 : mk(7, 0, 0, 1, 0);
        c = $urandom_range(0, 11);
        if (c == 0) r[15:12] = r[15:12] ^ 4'h1;
        if (c == 1) r[11:0] = r[11:0] + 12'd1;
        if (c == 2) r[24] = 1'b0;
        if (c == 3) r[31:28] = 4'(1 + $urandom_range(0, 14));
        nb = exp_body(r, unk);
        if (c == 4) nb = nb + 1;
        if (c == 5 && nb > 0) nb = nb - 1;
        rsp(r, nb, k == nr - 1, "R7 random");
      end
      if (nr == 0) rsp(mk(1, 1, 0, 1, 0), 0, 1, "R9 random");
      idb = (idb + n) % 4096;
    end

    // R12: overflow at QDEPTH
    chk(q_ovf_o == 0, "R12 no ovf yet", q_ovf_o, 0);
    for (int k = 0; k < 81; k++) push(mk(k, 1, 0, 0, 0));
    chk(q_ovf_o == movf, "R12 ovf", q_ovf_o, movf);
    rsp_for(mk(0, 1, 0, 0, 0), 1, "R12 drain");
    chk(q_ovf_o == 1, "R12 sticky", q_ovf_o, 1);
    push(mk(50, 1, 0, 0, 0));
    rsp_for(mk(50, 1, 0, 0, 0), 1, "R12 after flush");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule